// File: doc/BRIEF.md
# Exact-Order LRU Replacement Tracker

This block records, for every index of a set-associative cache, the complete ranking of its ways from least to most recently used. The ranking is kept as a small permutation number: the lexicographic rank of the order string, with position 0 holding the least recent way. One way needs 1 bit, two ways 1 bit, three ways 3 bits and four ways 5 bits. A 2-way entry is just the number of its least recent way. A 1-way entry is never changed. Every access to an index moves the touched way to the most-recent end. The other ways keep their relative order.

When the cache misses, a victim way is chosen for a probed index. The choice takes a floor value, so a contiguous group of low-numbered ways (for example locked ones) can be excluded. The victim is the first way, counted from the least-recent end, whose number is at least the floor. A floor above the highest way acts as the highest way. The ranking update is a read-modify-write of a state array with a registered read port. The edge after an access captures it, the next edge writes it back, and a forwarding path covers accesses that follow back to back on one index. In 4-way mode the eight unused codes update as if they held the reversed order, and their victim is way 0. In 3-way mode the two unused codes act fully as the reversed order.

Top module: `lru_perm_tracker`

## Requirements
- R1: After reset every index holds the identity order (way 0 least recent, highest way most recent), so a probe with floor f returns way f.
- R2: An access to way w moves w to the most-recent position and keeps the relative order of all other ways.
- R3: The victim is the first way, scanning from least to most recent, whose number is at least the floor.
- R4: With the floor equal to the highest way number, the victim is always the highest way.
- R5: An access presented in one cycle is reflected in the victim output from the cycle after the next clock edge.
- R6: Accesses to the same index in consecutive cycles each take effect, in order, with no update lost.
- R7: An access to one index leaves the order of every other index unchanged.
- R8: A flush returns every index to the identity order at the next edge. An access presented in the flush cycle and one still in flight are both discarded.
- R9: Accessing the way that is already most recent leaves the order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears every index to the identity order |
| acc_valid | input | 1 | An access to a way is presented this cycle |
| acc_index | input | IDX_W | Cache index of the access |
| acc_way | input | WAY_W | Way that was accessed |
| victim_index | input | IDX_W | Index probed for a victim |
| victim_floor | input | WAY_W | Lowest way number that may be chosen |
| victim_way | output | WAY_W | Chosen victim way for the probed index |

## Verification
The bench goes after bursts of accesses to one index on consecutive cycles. Without forwarding, the second update would build on a stale ranking and silently undo the first. It also probes an index while an update to it is still in flight. A design missing the bypass would report a way as victim that was just used. Flushes are issued with an access in the same cycle and another one pending. A design that let either survive would show a non-identity order after the flush. Floors from 0 to the top way are swept over shuffled orders, which exposes a scan that starts from the wrong end or that treats the floor as exclusive.

// File: rtl/lru_perm_pkg.sv
package lru_perm_pkg;

    localparam int MAX_WAYS = 4;

    // order[0] is the least recently used way, order[n-1] the most recent
    typedef logic [MAX_WAYS-1:0][1:0] order_t;

    function automatic int fact(input int n);
        int r;
        r = 1;
        for (int i = 2; i <= MAX_WAYS; i++)
            if (i <= n) r = r * i;
        return r;
    endfunction

    function automatic int code_width(input int ways);
        if (ways <= 2) return 1;
        if (ways == 3) return 3;
        return 5;
    endfunction

    function automatic int clamp_floor(input int f, input int n);
        return (f > n - 1) ? n - 1 : f;
    endfunction

    // permutation number -> order string
    function automatic order_t unrank(input int code, input int n);
        order_t o;
        logic [MAX_WAYS-1:0] used;
        int rem, f, q, cnt;
        o    = '0;
        used = '0;
        rem  = code;
        for (int i = 0; i < MAX_WAYS; i++) begin
            if (i < n) begin
                f   = fact(n - 1 - i);
                q   = rem / f;
                rem = rem % f;
                cnt = 0;
                for (int v = 0; v < MAX_WAYS; v++) begin
                    if (v < n && !used[v]) begin
                        if (cnt == q) begin
                            o[i]    = 2'(v);
                            used[v] = 1'b1;
                        end
                        cnt++;
                    end
                end
            end
        end
        return o;
    endfunction

    // order string -> permutation number
    function automatic int rank(input order_t o, input int n);
        int r, c;
        r = 0;
        for (int i = 0; i < MAX_WAYS; i++) begin
            if (i < n) begin
                c = 0;
                for (int j = 0; j < MAX_WAYS; j++)
                    if (j > i && j < n && o[j] < o[i]) c++;
                r = r + c * fact(n - 1 - i);
            end
        end
        return r;
    endfunction

    function automatic order_t reversed(input int n);
        order_t o;
        o = '0;
        for (int i = 0; i < MAX_WAYS; i++)
            if (i < n) o[i] = 2'(n - 1 - i);
        return o;
    endfunction

    // move way w to the most-recent end, keep the rest in order
    function automatic order_t touch(input order_t o, input int n, input int w);
        order_t r;
        int k;
        if (w >= n) return o;
        r = '0;
        k = 0;
        for (int i = 0; i < MAX_WAYS; i++) begin
            if (i < n && int'(o[i]) != w) begin
                r[k] = o[i];
                k++;
            end
        end
        r[n-1] = 2'(w);
        return r;
    endfunction

    function automatic int pick(input order_t o, input int n, input int f);
        int fe, res;
        logic found;
        fe    = clamp_floor(f, n);
        res   = n - 1;
        found = 1'b0;
        for (int i = 0; i < MAX_WAYS; i++) begin
            if (i < n && !found && int'(o[i]) >= fe) begin
                res   = int'(o[i]);
                found = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/lru_state_ram.sv
module lru_state_ram #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6,
    parameter int CODE_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [CODE_W-1:0] rd_q,
    input  logic [IDX_W-1:0]  peek_addr,
    output logic [CODE_W-1:0] peek_q,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [CODE_W-1:0] wr_data
);

    logic [CODE_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
            rd_q <= '0;
        end else begin
            if (wr_en) mem[wr_addr] <= wr_data;
            rd_q <= mem[rd_addr];
        end
    end

    // asynchronous port for the miss path
    assign peek_q = mem[peek_addr];

endmodule

// File: rtl/lru_next_code.sv
module lru_next_code
    import lru_perm_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int CODE_W = 5,
    parameter int WAY_W  = 2
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [WAY_W-1:0]  way_i,
    output logic [CODE_W-1:0] code_o
);

    generate
        if (WAYS == 1) begin : g_single
            logic unused_way;
            assign unused_way = ^way_i;
            assign code_o     = code_i;
        end else begin : g_multi
            order_t ord;
            always_comb begin
                // unused codes behave as the fully reversed order
                if (int'(code_i) < fact(WAYS)) ord = unrank(int'(code_i), WAYS);
                else                           ord = reversed(WAYS);
                code_o = CODE_W'(rank(touch(ord, WAYS, int'(way_i)), WAYS));
            end
        end
    endgenerate

endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel
    import lru_perm_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int CODE_W = 5,
    parameter int WAY_W  = 2
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [WAY_W-1:0]  floor_i,
    output logic [WAY_W-1:0]  way_o
);

    generate
        if (WAYS == 1) begin : g_single
            logic unused_in;
            assign unused_in = ^{code_i, floor_i};
            assign way_o     = '0;
        end else begin : g_multi
            always_comb begin
                if (int'(code_i) < fact(WAYS))
                    way_o = WAY_W'(pick(unrank(int'(code_i), WAYS), WAYS, int'(floor_i)));
                else if (WAYS == 4)
                    way_o = '0;   // unused 4-way codes always name way 0
                else
                    way_o = WAY_W'(pick(reversed(WAYS), WAYS, int'(floor_i)));
            end
        end
    endgenerate

endmodule

// File: rtl/lru_perm_tracker.sv
module lru_perm_tracker
    import lru_perm_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 64,
    localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W  = (WAYS > 2) ? 2 : 1,
    localparam int CODE_W = code_width(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_index,
    input  logic [WAY_W-1:0] acc_way,
    input  logic [IDX_W-1:0] victim_index,
    input  logic [WAY_W-1:0] victim_floor,
    output logic [WAY_W-1:0] victim_way
);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [WAY_W-1:0] way;
    } pend_t;

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [CODE_W-1:0] code;
    } wb_t;

    pend_t             pend;
    wb_t               last_wr;
    logic [CODE_W-1:0] rd_code, peek_code, base_code, new_code, vic_code;

    // stage 1: capture the access while the array read is in flight
    always_ff @(posedge clk) begin
        if (rst || flush) pend <= '0;
        else              pend <= '{vld: acc_valid, idx: acc_index, way: acc_way};
    end

    // remember the last write to forward over the registered read
    always_ff @(posedge clk) begin
        if (rst || flush) last_wr <= '0;
        else              last_wr <= '{vld: pend.vld, idx: pend.idx, code: new_code};
    end

    assign base_code = (last_wr.vld && last_wr.idx == pend.idx) ? last_wr.code : rd_code;

    lru_state_ram #(.ENTRIES(SETS), .IDX_W(IDX_W), .CODE_W(CODE_W)) u_ram (
        .clk      (clk),
        .rst      (rst),
        .clear    (flush),
        .rd_addr  (acc_index),
        .rd_q     (rd_code),
        .peek_addr(victim_index),
        .peek_q   (peek_code),
        .wr_en    (pend.vld),
        .wr_addr  (pend.idx),
        .wr_data  (new_code)
    );

    lru_next_code #(.WAYS(WAYS), .CODE_W(CODE_W), .WAY_W(WAY_W)) u_next (
        .code_i(base_code),
        .way_i (pend.way),
        .code_o(new_code)
    );

    // the miss path sees an update that has not yet been written back
    assign vic_code = (pend.vld && pend.idx == victim_index) ? new_code : peek_code;

    lru_victim_sel #(.WAYS(WAYS), .CODE_W(CODE_W), .WAY_W(WAY_W)) u_vic (
        .code_i (vic_code),
        .floor_i(victim_floor),
        .way_o  (victim_way)
    );

endmodule

// File: rtl/lru_perm_tracker_chk.sv
module lru_perm_tracker_chk
    import lru_perm_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int IDX_W = 6,
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             acc_valid,
    input logic [IDX_W-1:0] acc_index,
    input logic [WAY_W-1:0] acc_way,
    input logic [IDX_W-1:0] victim_index,
    input logic [WAY_W-1:0] victim_floor,
    input logic [WAY_W-1:0] victim_way
);

    int floor_eff;
    assign floor_eff = clamp_floor(int'(victim_floor), WAYS);

    p_victim_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        int'(victim_way) < WAYS);

    p_victim_above_floor_r3: assert property (@(posedge clk) disable iff (rst)
        (floor_eff <= WAYS - 1) |-> int'(victim_way) >= floor_eff);

    p_reset_identity_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> int'(victim_way) == floor_eff);

    p_flush_identity_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> int'(victim_way) == floor_eff);

    generate
        if (WAYS > 1) begin : g_mru
            p_mru_not_victim_r2: assert property (@(posedge clk) disable iff (rst)
                (acc_valid && !flush && int'(acc_way) < WAYS)
                |=> ((victim_index == $past(acc_index) && victim_floor == '0)
                     -> victim_way != $past(acc_way)));
        end
    endgenerate

endmodule

bind lru_perm_tracker lru_perm_tracker_chk #(.WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .acc_valid   (acc_valid),
    .acc_index   (acc_index),
    .acc_way     (acc_way),
    .victim_index(victim_index),
    .victim_floor(victim_floor),
    .victim_way  (victim_way)
);

// File: tb/lru_perm_tracker_test.sv
module lru_perm_tracker_test;

    localparam int WAYS  = 4;
    localparam int SETS  = 8;
    localparam int IDX_W = 3;
    localparam int WAY_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic             acc_valid = 1'b0;
    logic [IDX_W-1:0] acc_index = '0;
    logic [WAY_W-1:0] acc_way = '0;
    logic [IDX_W-1:0] victim_index = '0;
    logic [WAY_W-1:0] victim_floor = '0;
    logic [WAY_W-1:0] victim_way;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int    exp_q[$];
    string tag_q[$];
    int    model[SETS][WAYS];   // model[i][0] is least recent

    always #5 clk = ~clk;

    lru_perm_tracker #(.WAYS(WAYS), .SETS(SETS)) uut (
        .clk(clk), .rst(rst), .flush(flush),
        .acc_valid(acc_valid), .acc_index(acc_index), .acc_way(acc_way),
        .victim_index(victim_index), .victim_floor(victim_floor),
        .victim_way(victim_way)
    );

    function automatic void model_reset();
        for (int i = 0; i < SETS; i++)
            for (int k = 0; k < WAYS; k++) model[i][k] = k;
    endfunction

    function automatic void model_touch(input int idx, input int w);
        int k;
        int tmp[WAYS];
        k = 0;
        for (int p = 0; p < WAYS; p++)
            if (model[idx][p] != w) begin tmp[k] = model[idx][p]; k++; end
        tmp[WAYS-1] = w;
        for (int p = 0; p < WAYS; p++) model[idx][p] = tmp[p];
    endfunction

    function automatic int model_pick(input int idx, input int f);
        for (int p = 0; p < WAYS; p++)
            if (model[idx][p] >= f) return model[idx][p];
        return WAYS - 1;
    endfunction

    // driver: one cycle of stimulus plus one expected victim
    task automatic step(input bit av, input int ai, input int aw, input bit fl,
                        input int vi, input int vf, input string tag);
        @(negedge clk);
        acc_valid    = av;
        acc_index    = IDX_W'(ai);
        acc_way      = WAY_W'(aw);
        flush        = fl;
        victim_index = IDX_W'(vi);
        victim_floor = WAY_W'(vf);
        exp_q.push_back(model_pick(vi, vf));
        tag_q.push_back(tag);
        if (fl)      model_reset();
        else if (av) model_touch(ai, aw);
    endtask

    task automatic probe(input int vi, input int vf, input string tag);
        step(1'b0, 0, 0, 1'b0, vi, vf, tag);
    endtask

    // monitor: compare mid-cycle, away from the edges
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (int'(victim_way) != e) begin
                errors++;
                $display("FAIL %s: victim actual=%0d expected=%0d (idx=%0d floor=%0d)",
                         t, victim_way, e, victim_index, victim_floor);
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: identity order everywhere after reset
        for (int f = 0; f < WAYS; f++) probe(0, f, "R1");
        for (int f = 0; f < WAYS; f++) probe(SETS - 1, f, "R1");

        // R2 / R5: way 0 becomes most recent, visible the next cycle
        step(1'b1, 1, 0, 1'b0, 1, 0, "R5");
        probe(1, 0, "R5");
        for (int f = 0; f < WAYS; f++) probe(1, f, "R2");
        // R9: re-touching the most recent way changes nothing
        step(1'b1, 1, 0, 1'b0, 1, 0, "R9");
        for (int f = 0; f < WAYS; f++) probe(1, f, "R9");

        // R6: back-to-back accesses to one index, probed while in flight
        step(1'b1, 2, 3, 1'b0, 2, 0, "R6");
        step(1'b1, 2, 0, 1'b0, 2, 0, "R6");
        step(1'b1, 2, 1, 1'b0, 2, 0, "R6");
        step(1'b1, 2, 2, 1'b0, 2, 1, "R6");
        for (int f = 0; f < WAYS; f++) probe(2, f, "R6");

        // R7: other indices are untouched
        step(1'b1, 4, 0, 1'b0, 5, 0, "R7");
        step(1'b1, 4, 1, 1'b0, 5, 1, "R7");
        for (int f = 0; f < WAYS; f++) probe(5, f, "R7");
        for (int f = 0; f < WAYS; f++) probe(4, f, "R3");

        // R4: top floor always picks the top way
        step(1'b1, 6, 3, 1'b0, 6, 3, "R4");
        probe(6, 3, "R4");

        // R3: shuffled traffic, concentrated on few indices
        seed = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            step(seed[16], int'(seed[18:17]), int'(seed[21:20]), 1'b0,
                 int'(seed[24:23]), int'(seed[27:26]), "R3");
        end

        // R8: flush with one access in flight and one in the same cycle
        step(1'b1, 3, 1, 1'b0, 3, 0, "R8");
        step(1'b1, 3, 2, 1'b1, 3, 0, "R8");
        for (int f = 0; f < WAYS; f++) probe(3, f, "R8");
        for (int f = 0; f < WAYS; f++) probe(1, f, "R8");

        @(negedge clk);
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule